// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command bus of an SDR SDRAM from reset until the memory can be used. While reset is held, it drives command-inhibit. Once reset is released, it first holds the bus at NOP for a power-up delay. It then closes every bank with a precharge-all command and runs two auto-refresh cycles. Last, it writes the supplied mode word into the device's mode register. When the mode-register wait has run out, it raises a done flag. From then on the bus stays at NOP, so a normal controller can take over.

All waits are given on input ports as counts of clock cycles. Each wait is the distance from one command to the next. A count of zero is treated as one. The order of the phases is fixed and cannot be skipped. The mode register is only written after the precharge and both refreshes.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_n is low, cs_n is 1 (command-inhibit) and init_done is 0.
- R2: Cycle 0 is the first cycle after reset is released. From cycle 0, the bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111) for max(pwr_cycles,1) cycles.
- R3: The precharge-all command (0010) appears next, for exactly one cycle, with addr bit 10 = 1, all other addr bits 0, and ba = 0.
- R4: The first auto-refresh (0001) comes exactly max(trp_cycles,1) cycles after the precharge, with NOPs in between.
- R5: The second auto-refresh (0001) comes exactly max(trfc_cycles,1) cycles after the first one, with NOPs in between.
- R6: The load-mode-register command (0000) comes max(trfc_cycles,1) cycles after the second refresh. It carries addr = mode_word and ba = 0, and it is never issued before both refreshes.
- R7: init_done rises exactly max(tmrd_cycles,1) cycles after the load-mode-register cycle. Every cycle in between is NOP.
- R8: Once init_done is high, it stays high and the bus stays at NOP until the next reset.
- R9: Asserting reset partway through the sequence restarts it from the power-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | AW | Value written to the mode register |
| pwr_cycles | input | CW | Power-up delay, in cycles |
| trp_cycles | input | CW | Cycles from precharge to the next command |
| trfc_cycles | input | CW | Cycles from a refresh to the next command |
| tmrd_cycles | input | CW | Cycles from mode load to done |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | AW | Address bus |
| ba | output | BW | Bank address |
| init_done | output | 1 | Initialization complete |

## Verification
An error in the phase register or the interval counter shows up on the command pins within one cycle. A command then appears at the wrong cycle index, or it lasts longer than a single cycle. An early command is exposed right away, because the bench predicts the exact cycle of every command and compares the bus on every cycle. A wrong refresh count or a skipped phase shows up as a mode load at the wrong position, or as init_done asserting at the wrong time.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int AW = 12,
  parameter int BW = 2,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] mode_word,
  input  logic [CW-1:0] pwr_cycles,
  input  logic [CW-1:0] trp_cycles,
  input  logic [CW-1:0] trfc_cycles,
  input  logic [CW-1:0] tmrd_cycles,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] ba,
  output logic          init_done
);

  localparam logic [3:0] C_INH = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef enum logic [2:0] {PH_PWR, PH_PRE, PH_RF1, PH_RF2, PH_LMR, PH_DONE} phase_t;

  phase_t        ph, ph_nx;
  logic [CW-1:0] cnt, len_raw, len;
  logic [3:0]    cmd;
  logic          last, issue;

  always_comb begin
    case (ph)
      PH_PWR:         len_raw = pwr_cycles;
      PH_PRE:         len_raw = trp_cycles;
      PH_RF1, PH_RF2: len_raw = trfc_cycles;
      PH_LMR:         len_raw = tmrd_cycles;
      default:        len_raw = CW'(1);
    endcase
  end

  assign len   = (len_raw == '0) ? CW'(1) : len_raw;
  assign last  = (cnt == len - CW'(1));
  assign issue = (cnt == '0);

  always_comb begin
    case (ph)
      PH_PWR:  ph_nx = PH_PRE;
      PH_PRE:  ph_nx = PH_RF1;
      PH_RF1:  ph_nx = PH_RF2;
      PH_RF2:  ph_nx = PH_LMR;
      default: ph_nx = PH_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_PWR;
      cnt <= '0;
    end else if (ph != PH_DONE) begin
      if (last) begin
        ph  <= ph_nx;
        cnt <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_comb begin
    cmd = C_NOP;
    if (!rst_n) cmd = C_INH;
    else if (issue) begin
      case (ph)
        PH_PRE:         cmd = C_PRE;
        PH_RF1, PH_RF2: cmd = C_REF;
        PH_LMR:         cmd = C_LMR;
        default:        cmd = C_NOP;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign addr = (rst_n && issue && ph == PH_LMR) ? mode_word :
                (rst_n && issue && ph == PH_PRE) ? (AW'(1) << 10) : '0;
  assign ba        = '0;
  assign init_done = (ph == PH_DONE);

  logic [1:0] refs_seen;
  logic       pre_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refs_seen <= '0;
      pre_seen  <= 1'b0;
    end else begin
      if (cmd == C_REF && refs_seen != 2'd3) refs_seen <= refs_seen + 2'd1;
      if (cmd == C_PRE) pre_seen <= 1'b1;
    end
  end

  // R3
  pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> (addr[10] && ba == '0));
  // R4
  ref_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |-> pre_seen);
  // R6
  lmr_after_refs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_LMR) |-> (refs_seen == 2'd2));
  // R7
  done_after_refs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (refs_seen == 2'd2 && pre_seen));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && cmd == C_NOP));

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int AW = 12;
  localparam int BW = 2;
  localparam int CW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mode_word = '0;
  logic [CW-1:0] pwr_cycles = '0, trp_cycles = '0, trfc_cycles = '0, tmrd_cycles = '0;
  logic          cs_n, ras_n, cas_n, we_n, init_done;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;

  int tests = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq #(.AW(AW), .BW(BW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word),
    .pwr_cycles(pwr_cycles), .trp_cycles(trp_cycles),
    .trfc_cycles(trfc_cycles), .tmrd_cycles(tmrd_cycles),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done));

  function automatic int clamp1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) begin
      #1;
      chk("R1 inhibit", {31'd0, cs_n}, 32'd1);
      chk("R1 done low", {31'd0, init_done}, 32'd0);
      @(negedge clk);
    end
    rst_n = 1'b1;
  endtask

  task automatic run_seq(input int p, input int rp, input int rfc, input int mrd,
                         input logic [AW-1:0] mw);
    int t_pre, t_r1, t_r2, t_l, t_d;
    pwr_cycles = CW'(p); trp_cycles = CW'(rp);
    trfc_cycles = CW'(rfc); tmrd_cycles = CW'(mrd); mode_word = mw;
    do_reset();
    t_pre = clamp1(p);
    t_r1  = t_pre + clamp1(rp);
    t_r2  = t_r1 + clamp1(rfc);
    t_l   = t_r2 + clamp1(rfc);
    t_d   = t_l + clamp1(mrd);
    for (int i = 0; i <= t_d + 4; i++) begin
      logic [3:0] c;
      #1;
      c = {cs_n, ras_n, cas_n, we_n};
      if (i < t_pre)       chk("R2 power-up NOP", c, 4'b0111);
      else if (i == t_pre) begin
        chk("R3 precharge", c, 4'b0010);
        chk("R3 precharge addr", addr, 32'h400);
        chk("R3 precharge ba", ba, 0);
      end
      else if (i < t_r1)   chk("R4 NOP after precharge", c, 4'b0111);
      else if (i == t_r1)  chk("R4 first refresh", c, 4'b0001);
      else if (i < t_r2)   chk("R5 NOP after refresh", c, 4'b0111);
      else if (i == t_r2)  chk("R5 second refresh", c, 4'b0001);
      else if (i < t_l)    chk("R6 NOP before mode load", c, 4'b0111);
      else if (i == t_l) begin
        chk("R6 mode load", c, 4'b0000);
        chk("R6 mode addr", addr, mw);
        chk("R6 mode ba", ba, 0);
      end
      else if (i < t_d)    chk("R7 NOP during mode wait", c, 4'b0111);
      else                 chk("R8 NOP after done", c, 4'b0111);
      if (i < t_d) chk("R7 done timing", {31'd0, init_done}, 0);
      else         chk("R8 done held", {31'd0, init_done}, 1);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    run_seq(1, 1, 1, 1, 12'h033);
    run_seq(0, 0, 0, 0, 12'hFFF);
    run_seq(20, 3, 7, 2, 12'h237);
    // R9: reset in mid-sequence, then a full run must start over
    pwr_cycles = 5; trp_cycles = 2; trfc_cycles = 4; tmrd_cycles = 2;
    do_reset();
    repeat (9) @(negedge clk);
    run_seq(5, 2, 4, 2, 12'h0A5);
    chk("R9 restart complete", {31'd0, init_done}, 1);
    for (int k = 0; k < 20; k++)
      run_seq($urandom_range(0, 400), $urandom_range(0, 9), $urandom_range(0, 12),
              $urandom_range(0, 5), AW'($urandom));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule